// File: doc/BRIEF.md
# Snapshot-Read Interval Timer

This block is a single-channel periodic timer behind an 8-bit register port. A 22-bit up-counter runs from zero to a software-chosen terminal value, returns to zero, and can raise a level interrupt each time it does so. A strap input tells the block that its bus clock runs at twice the nominal counting rate. In that case the block lets the counter step only on every second clock, so the count rate is the same for either strap setting.

Software places the terminal value in a reload register one byte at a time, and starts or stops the timer through a two-bit control register. To read the count, software first reads the lowest latch address. That read copies the whole live count into a snapshot, so the upper bytes read later all come from the same instant. The read layout packs six count bits per byte and leaves a hole at bit 5, so it differs from the write layout. An interrupt is acknowledged by clearing the interrupt-enable bit and then setting it again. A build option narrows the counter to 19 bits.

Top module: `itv_timer`

## Requirements
- R1: After reset the control register reads 0x00, a snapshot read returns 0x00, and `irq` is low.
- R2: The control register is at address 4, with bit 0 as count enable and bit 1 as interrupt enable. Both bits read back as written, and bits 7:2 always read 0.
- R3: Each write lands in the reload register as follows: address 0 fills bits 7:0, address 1 fills bits 15:8, and address 2 fills bits 21:16 from its data bits 5:0. With the narrow build option only bits 18:0 are kept.
- R4: Count enable is set at some edge. From the second edge after that one, each count tick adds one to the counter, until the counter equals the terminal value. The next tick returns it to 0, so the period is terminal+1 ticks.
- R5: While `fast_strap` is high there is one count tick every two clocks. While it is low there is one tick every clock.
- R6: A read of address 0 copies the live count into the snapshot in the same edge. Reads of addresses 1 to 3 return parts of the snapshot and not of the live count. `bus_rdata` is registered: it is valid one clock after the read strobe and holds until the next read.
- R7: Read bytes 0, 1 and 2 carry count groups 5:0, 11:6 and 17:12. Each such byte holds the low 5 group bits in bits 4:0 and the group's top bit in bit 6, and reads 0 in bits 7 and 5. Read byte 3 holds count bits 21:18 in bits 3:0 and 0 elsewhere.
- R8: While count enable is clear, the counter is held at 0.
- R9: The counter takes up a new reload value only when count enable next goes from clear to set. Writes made while it runs do not change the current period.
- R10: A wrap with interrupt enable set drives `irq` high from the next clock, and it stays high. Clearing interrupt enable drops `irq` in the same edge. A wrap that happens while interrupt enable is clear raises nothing, and setting the bit again arms the interrupt for later wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_strap | input | 1 | High when the bus clock is twice the count rate |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
A bad terminal register or a bad reload path changes the wrap point. That shows up on the first snapshot read taken past the intended terminal value, and on the timing of the first `irq` rise, within one period. A stale or wrongly loaded snapshot makes reads of addresses 1 to 3 disagree with the packed value of the count that the address-0 read captured, and this shows on the very next read. A wrong prescaler phase shows as a count difference between two reads a known number of clocks apart. A pending flag that is not cleared shows as `irq` still high on the clock after the acknowledging write.

// File: rtl/itv_pkg.sv
package itv_pkg;

    localparam int FULL_W   = 22;
    localparam int NARROW_W = 19;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int GROUP_W  = 6;

    typedef logic [FULL_W-1:0] itv_count_t;
    typedef logic [BYTE_W-1:0] itv_byte_t;

    typedef enum logic [ADDR_W-1:0] {
        A_LAT0 = 3'd0,
        A_LAT1 = 3'd1,
        A_LAT2 = 3'd2,
        A_LAT3 = 3'd3,
        A_CTRL = 3'd4
    } itv_addr_e;

    // bit 1 = interrupt enable, bit 0 = count enable
    typedef struct packed {
        logic irq_en;
        logic cnt_en;
    } itv_ctrl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } itv_state_e;

    // One 6-bit count group in read layout: bit 6 = group msb, bit 5 = 0
    function automatic itv_byte_t pack_group(logic [GROUP_W-1:0] g);
        return {1'b0, g[5], 1'b0, g[4:0]};
    endfunction

    function automatic itv_byte_t pack_byte(itv_count_t c, logic [1:0] sel);
        itv_byte_t b;
        case (sel)
            2'd0:    b = pack_group(c[5:0]);
            2'd1:    b = pack_group(c[11:6]);
            2'd2:    b = pack_group(c[17:12]);
            default: b = {4'b0000, c[21:18]};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/itv_prescale.sv
module itv_prescale (
    input  logic clk,
    input  logic rst,
    input  logic fast_strap,
    output logic tick
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= ~phase_q;
    end

    assign tick = ~fast_strap | phase_q;

    // R5
    strap_half_chk: assert property (@(posedge clk) disable iff (rst)
        (fast_strap && tick) |=> (!fast_strap || !tick));

    // R5
    slow_every_chk: assert property (@(posedge clk) disable iff (rst)
        !fast_strap |-> tick);

endmodule

// File: rtl/itv_counter.sv
module itv_counter
    import itv_pkg::*;
#(
    parameter int CNT_W = FULL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    itv_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term_q;

    assign wrap  = (st_q == ST_RUN) && cnt_en && tick && (cnt_q == term_q);
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            term_q <= '0;
        end else if (!cnt_en) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else if (st_q == ST_IDLE) begin
            st_q   <= ST_RUN;
            term_q <= reload;
        end else if (tick) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    // R8
    hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> (count == '0));

    // R4
    step_chk: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_RUN) && cnt_en && tick && !wrap) |=> (count == $past(count) + 1'b1));

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (count == '0));

    // R9
    term_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_RUN) && cnt_en) |=> $stable(term_q));

    // R4
    bound_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN) |-> (count <= term_q));

endmodule

// File: rtl/itv_regs.sv
module itv_regs
    import itv_pkg::*;
#(
    parameter int CNT_W = FULL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              wrap,
    output itv_ctrl_t         ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq
);
    itv_ctrl_t        ctrl_q, ctrl_n;
    logic [CNT_W-1:0] reload_q;
    itv_count_t       reload_full;
    itv_count_t       count_full;
    itv_count_t       snap_q, snap_n;
    itv_byte_t        rdata_q, rdata_n;
    logic             irq_q, irq_n;
    itv_addr_e        addr;

    assign addr       = itv_addr_e'(bus_addr);
    assign count_full = itv_count_t'(count);

    // write path
    always_comb begin
        reload_full = itv_count_t'(reload_q);
        ctrl_n      = ctrl_q;
        if (bus_wr) begin
            case (addr)
                A_LAT0:  reload_full[7:0]   = bus_wdata;
                A_LAT1:  reload_full[15:8]  = bus_wdata;
                A_LAT2:  reload_full[21:16] = bus_wdata[5:0];
                A_CTRL:  ctrl_n             = itv_ctrl_t'(bus_wdata[1:0]);
                default: ;
            endcase
        end
    end

    // read path
    always_comb begin
        snap_n  = snap_q;
        rdata_n = rdata_q;
        if (bus_rd) begin
            case (addr)
                A_LAT0: begin
                    snap_n  = count_full;
                    rdata_n = pack_byte(count_full, 2'd0);
                end
                A_LAT1:  rdata_n = pack_byte(snap_q, 2'd1);
                A_LAT2:  rdata_n = pack_byte(snap_q, 2'd2);
                A_LAT3:  rdata_n = pack_byte(snap_q, 2'd3);
                A_CTRL:  rdata_n = {6'b000000, ctrl_q};
                default: rdata_n = '0;
            endcase
        end
    end

    // interrupt: clearing enable wins over a same-cycle wrap
    assign irq_n = ctrl_n.irq_en & (irq_q | (wrap & ctrl_q.irq_en));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            snap_q   <= '0;
            rdata_q  <= '0;
            irq_q    <= 1'b0;
        end else begin
            ctrl_q   <= ctrl_n;
            reload_q <= reload_full[CNT_W-1:0];
            snap_q   <= snap_n;
            rdata_q  <= rdata_n;
            irq_q    <= irq_n;
        end
    end

    assign ctrl      = ctrl_q;
    assign reload    = reload_q;
    assign bus_rdata = rdata_q;
    assign irq       = irq_q;

    // R10
    irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.irq_en |-> !irq);

    // R10
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap && ctrl_q.irq_en && !(bus_wr && addr == A_CTRL)) |=> irq);

    // R6
    snap_take_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && addr == A_LAT0) |=> (snap_q == itv_count_t'($past(count))));

    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R2
    ctrl_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && addr == A_CTRL) |=> (bus_rdata[7:2] == 6'b000000));

endmodule

// File: rtl/itv_timer.sv
module itv_timer
    import itv_pkg::*;
#(
    parameter bit NARROW_CNT = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fast_strap,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    localparam int CNT_W = NARROW_CNT ? NARROW_W : FULL_W;

    logic             tick;
    logic             wrap;
    itv_ctrl_t        ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;

    itv_prescale u_pre (
        .clk        (clk),
        .rst        (rst),
        .fast_strap (fast_strap),
        .tick       (tick)
    );

    itv_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (ctrl.cnt_en),
        .tick   (tick),
        .reload (reload),
        .count  (count),
        .wrap   (wrap)
    );

    itv_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .count     (count),
        .wrap      (wrap),
        .ctrl      (ctrl),
        .reload    (reload),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!irq && bus_rdata == 8'h00));

endmodule

// File: tb/tb_itv_timer.sv
`timescale 1ns/1ps
module tb_itv_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fast_strap = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    itv_timer dut (
        .clk(clk), .rst(rst), .fast_strap(fast_strap),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [7:0] bpack(int v, int idx);
        int g;
        if (idx == 3) return 8'((v >> 18) & 15);
        g = (v >> (6 * idx)) & 63;
        return 8'((((g >> 5) & 1) << 6) | (g & 31));
    endfunction

    function automatic int bunpack(logic [7:0] b);
        return int'(b[4:0]) + (b[6] ? 32 : 0);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_reload(int v);
        wr(3'd0, 8'(v));
        wr(3'd1, 8'(v >> 8));
        wr(3'd2, 8'(v >> 16));
    endtask

    task automatic restart(logic [7:0] ctl);
        wr(3'd4, 8'h00);
        wr(3'd4, ctl);
    endtask

    // snapshot after g idle clocks from enable gives (g-1) mod (T+1)
    function automatic int expect_cnt(int g, int t);
        return (g == 0) ? 0 : (g - 1) % (t + 1);
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        rd(3'd4, d); check("R1", "ctrl after reset", d, 0);
        rd(3'd0, d); check("R1", "count after reset", d, 0);
        check("R1", "irq after reset", irq, 0);
    endtask

    task automatic t_ctrl();
        logic [7:0] d;
        wr(3'd4, 8'h02); rd(3'd4, d); check("R2", "irq_en only", d, 8'h02);
        wr(3'd4, 8'hFC); rd(3'd4, d); check("R2", "upper bits ignored", d, 8'h00);
        wr(3'd4, 8'h03); rd(3'd4, d); check("R2", "both bits", d, 8'h03);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_count();
        logic [7:0] d;
        int gs[5] = '{1, 3, 6, 7, 9};
        set_reload(5);
        foreach (gs[i]) begin
            restart(8'h01);
            idle(gs[i]);
            rd(3'd0, d);
            check("R4", $sformatf("count g=%0d", gs[i]), d, bpack(expect_cnt(gs[i], 5), 0));
        end
    endtask

    task automatic t_pack();
        logic [7:0] d;
        set_reload(32'h3FFFFF);
        restart(8'h01);
        idle(64);
        rd(3'd0, d); check("R7", "byte0 of 63", d, 8'h5F);
        idle(5);
        rd(3'd1, d); check("R6", "byte1 from snapshot", d, 8'h00);
        restart(8'h01);
        idle(70000);
        rd(3'd0, d); check("R7", "byte0 of 69999", d, bpack(69999, 0));
        rd(3'd1, d); check("R7", "byte1 of 69999", d, bpack(69999, 1));
        rd(3'd2, d); check("R3", "byte2 of 69999 (high reload bits)", d, bpack(69999, 2));
        rd(3'd3, d); check("R7", "byte3 of 69999", d, bpack(69999, 3));
    endtask

    task automatic t_reload_mid();
        logic [7:0] d;
        set_reload(32'h105);
        restart(8'h01);
        idle(262);
        rd(3'd0, d); check("R3", "byte0 of 261", d, bpack(261, 0));
        rd(3'd1, d); check("R3", "byte1 of 261", d, bpack(261, 1));
        restart(8'h01);
        idle(263);
        rd(3'd0, d); check("R4", "wrap after 0x105", d, 8'h00);
    endtask

    task automatic t_disable();
        logic [7:0] d;
        set_reload(100);
        restart(8'h01);
        idle(30);
        wr(3'd4, 8'h00);
        idle(5);
        rd(3'd0, d); check("R8", "byte0 while disabled", d, 8'h00);
        rd(3'd1, d); check("R8", "byte1 while disabled", d, 8'h00);
    endtask

    task automatic t_defer();
        logic [7:0] d;
        set_reload(3);
        restart(8'h01);
        set_reload(50);
        for (int k = 0; k < 6; k++) begin
            idle(k + 2);
            rd(3'd0, d);
            check("R9", "count stays within old terminal", (bunpack(d) <= 3) ? 1 : 0, 1);
        end
        restart(8'h01);
        idle(20);
        rd(3'd0, d); check("R9", "new terminal after re-enable", d, bpack(19, 0));
    endtask

    task automatic t_strap();
        logic [7:0] d;
        int a;
        fast_strap = 1'b1;
        set_reload(32'h3FFFFF);
        restart(8'h01);
        idle(4);
        rd(3'd0, d); a = bunpack(d);
        idle(39);
        rd(3'd0, d);
        check("R5", "half rate over 40 clocks", bunpack(d) - a, 20);
        fast_strap = 1'b0;
        wr(3'd4, 8'h00);
    endtask

    task automatic t_irq();
        set_reload(3);
        restart(8'h03);
        idle(4); check("R10", "irq before first wrap", irq, 0);
        idle(1); check("R10", "irq after first wrap", irq, 1);
        idle(6); check("R10", "irq level held", irq, 1);
        wr(3'd4, 8'h01); check("R10", "irq cleared by ack", irq, 0);
        idle(10); check("R10", "no irq while disabled", irq, 0);
        wr(3'd4, 8'h03); check("R10", "no stale irq on re-arm", irq, 0);
        idle(5); check("R10", "irq after re-arm", irq, 1);
        wr(3'd4, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_count();
        t_pack();
        t_reload_mid();
        t_disable();
        t_defer();
        t_strap();
        t_irq();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule